// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Interlock

This block steers the two execute-stage operands of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). For each operand it chooses between the value read from the register file at decode and a newer result still in flight. That newer result can sit in the memory stage, in the writeback stage, or in a small register that keeps the last writeback for one more cycle. Each producer stage has its own comparator and its own mux leg. When more than one stage matches, the youngest producer is used.

A load's data exists only after the memory stage, so a load cannot feed the instruction that directly follows it. The block detects this case: the load sits in execute and the consumer sits in decode. It then raises a hold for fetch and decode and a request to insert a noop into execute, for exactly that cycle. The second operand also serves as the store-data value and follows the same rules. Upstream logic chooses the writeback value: memory read data for loads, the ALU result for add and nand. That choice is outside this block.

Top module: `operand_bypass_ctrl`

## Requirements
- R1: When no valid later stage writes a register equal to an operand's source, that operand's select is 0 and the operand equals its decode-time value.
- R2: When the memory stage holds a non-load with a valid write to the operand's source, the select is 1 and the operand equals the memory-stage ALU result.
- R3: When the writeback stage has a valid write to the operand's source and no younger source applies, the select is 2 and the operand equals the writeback data.
- R4: The post-writeback register captures the writeback destination, data and write-valid on every clock edge. A match against it gives select 3 and the value written back one cycle earlier.
- R5: When several stages match, the youngest wins: the memory stage over writeback, and writeback over post-writeback.
- R6: A load in the memory stage is never a bypass source. A match against it falls through to the older stages.
- R7: When execute holds a writing load whose destination equals a used source of the instruction in decode (either operand), hold_front and insert_noop are both 1 in that same cycle.
- R8: No stall is raised if the decode source that matches is marked unused, or if the execute instruction is not a writing load.
- R9: A stage whose write-valid is 0 never matches, whatever its destination.
- R10: The two operands are resolved independently. Operand B (also the store data) may take a different source than operand A in the same cycle.
- R11: Reset clears the post-writeback valid bit, so no post-writeback match can occur in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ex_src_a | input | RW | Operand A source register in execute |
| ex_src_b | input | RW | Operand B / store-data source register in execute |
| ex_val_a | input | DW | Operand A value read at decode |
| ex_val_b | input | DW | Operand B value read at decode |
| ex_dest | input | RW | Destination of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| dec_src_a | input | RW | First source of the decode-stage instruction |
| dec_src_b | input | RW | Second source of the decode-stage instruction |
| dec_use_a | input | 1 | Decode instruction reads dec_src_a |
| dec_use_b | input | 1 | Decode instruction reads dec_src_b |
| mem_dest | input | RW | Memory-stage destination |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_alu | input | DW | Memory-stage ALU result |
| wb_dest | input | RW | Writeback destination |
| wb_wr | input | 1 | Writeback write-valid |
| wb_data | input | DW | Writeback data |
| sel_a | output | 2 | Operand A source: 0 decode, 1 memory, 2 writeback, 3 post-writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | DW | Resolved operand A |
| opnd_b | output | DW | Resolved operand B / store data |
| hold_front | output | 1 | Hold fetch and decode this cycle |
| insert_noop | output | 1 | Replace the instruction entering execute with a noop |

## Verification
The bench targets priority collisions, where the memory, writeback and post-writeback stages all name the same register. A design with the wrong priority order would hand execute a stale value. It drives a load in the memory stage that matches a source. A design missing the suppression would forward an address in place of the loaded data. It checks the post-writeback register one cycle after a write and across a reset. A wrong capture or reset would cause a false match or miss a real one. Stall cases vary the used flags and the load and write bits, to catch interlocks that fire on unused sources or on non-loads.

// File: rtl/operand_bypass_ctrl.sv
module operand_bypass_ctrl #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [DW-1:0] ex_val_a,
  input  logic [DW-1:0] ex_val_b,
  input  logic [RW-1:0] ex_dest,
  input  logic          ex_wr,
  input  logic          ex_is_load,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic          dec_use_a,
  input  logic          dec_use_b,
  input  logic [RW-1:0] mem_dest,
  input  logic          mem_wr,
  input  logic          mem_is_load,
  input  logic [DW-1:0] mem_alu,
  input  logic [RW-1:0] wb_dest,
  input  logic          wb_wr,
  input  logic [DW-1:0] wb_data,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic          hold_front,
  output logic          insert_noop
);

  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_WB  = 2'd2;
  localparam logic [1:0] SEL_PW  = 2'd3;

  logic [RW-1:0] pw_dest;
  logic [DW-1:0] pw_data;
  logic          pw_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_wr   <= 1'b0;
      pw_dest <= '0;
      pw_data <= '0;
    end else begin
      pw_wr   <= wb_wr;
      pw_dest <= wb_dest;
      pw_data <= wb_data;
    end
  end

  logic          mem_ok;
  logic [RW-1:0] srcs [2];
  logic [DW-1:0] vals [2];
  logic [1:0]    sels [2];
  logic [DW-1:0] outs [2];

  assign mem_ok  = mem_wr && !mem_is_load;
  assign srcs[0] = ex_src_a;
  assign srcs[1] = ex_src_b;
  assign vals[0] = ex_val_a;
  assign vals[1] = ex_val_b;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    always_comb begin
      if (mem_ok && mem_dest == srcs[i])       sels[i] = SEL_MEM;
      else if (wb_wr && wb_dest == srcs[i])    sels[i] = SEL_WB;
      else if (pw_wr && pw_dest == srcs[i])    sels[i] = SEL_PW;
      else                                     sels[i] = SEL_REG;
    end
    always_comb begin
      case (sels[i])
        SEL_MEM: outs[i] = mem_alu;
        SEL_WB:  outs[i] = wb_data;
        SEL_PW:  outs[i] = pw_data;
        default: outs[i] = vals[i];
      endcase
    end
  end

  assign sel_a  = sels[0];
  assign sel_b  = sels[1];
  assign opnd_a = outs[0];
  assign opnd_b = outs[1];

  logic load_use;
  assign load_use = ex_is_load && ex_wr &&
                    ((dec_use_a && dec_src_a == ex_dest) ||
                     (dec_use_b && dec_src_b == ex_dest));
  assign hold_front  = load_use;
  assign insert_noop = load_use;

  a_r1_reg_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SEL_REG) |-> (opnd_a == ex_val_a));
  a_r3_wb_value: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == SEL_WB) |-> (opnd_b == wb_data));
  a_r6_no_load_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_load |-> (sel_a != SEL_MEM && sel_b != SEL_MEM));
  a_r9_invalid_wb: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_wr |-> (sel_a != SEL_WB && sel_b != SEL_WB));
  a_r8_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |-> (ex_is_load && ex_wr && (dec_use_a || dec_use_b)));
  a_r7_noop_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
    insert_noop == hold_front);
  a_r4_pw_from_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_wr) |=> (sel_a != SEL_PW && sel_b != SEL_PW));

endmodule

// File: tb/operand_bypass_ctrl_tb.sv
`timescale 1ns/1ps
module operand_bypass_ctrl_tb;
  localparam int DW = 16;
  localparam int RW = 3;

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] ex_src_a, ex_src_b, ex_dest, dec_src_a, dec_src_b, mem_dest, wb_dest;
  logic [DW-1:0] ex_val_a, ex_val_b, mem_alu, wb_data;
  logic ex_wr, ex_is_load, dec_use_a, dec_use_b, mem_wr, mem_is_load, wb_wr;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;
  logic hold_front, insert_noop;

  always #2 clk = ~clk;

  operand_bypass_ctrl #(.DW(DW), .RW(RW)) u_dut (.*);

  typedef struct {
    logic [1:0] sa, sb;
    logic [DW-1:0] oa, ob;
    logic st;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;
  logic prev_wr = 0;
  logic [DW-1:0] prev_data = '0;

  function automatic logic [DW-1:0] val_for(logic [1:0] s, logic [DW-1:0] regv);
    case (s)
      2'd1: return mem_alu;
      2'd2: return wb_data;
      2'd3: return prev_data;
      default: return regv;
    endcase
  endfunction

  task automatic defaults();
    ex_src_a = 1; ex_src_b = 2; ex_val_a = 16'h1111; ex_val_b = 16'h2222;
    ex_dest = 0; ex_wr = 0; ex_is_load = 0;
    dec_src_a = 0; dec_src_b = 0; dec_use_a = 0; dec_use_b = 0;
    mem_dest = 0; mem_wr = 0; mem_is_load = 0; mem_alu = 16'hAAAA;
    wb_dest = 0; wb_wr = 0; wb_data = 16'hBBBB;
  endtask

  task automatic next();
    @(posedge clk); #1;
    defaults();
  endtask

  task automatic push(logic [1:0] sa, logic [1:0] sb, logic st, string tag);
    exp_t e;
    e.sa = sa; e.sb = sb; e.st = st; e.tag = tag;
    e.oa = val_for(sa, ex_val_a);
    e.ob = val_for(sb, ex_val_b);
    q.push_back(e);
    prev_wr = wb_wr; prev_data = wb_data;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "sel_a", sel_a, e.sa);
      chk(e.tag, "sel_b", sel_b, e.sb);
      chk(e.tag, "opnd_a", opnd_a, e.oa);
      chk(e.tag, "opnd_b", opnd_b, e.ob);
      chk(e.tag, "hold_front", hold_front, e.st);
      chk(e.tag, "insert_noop", insert_noop, e.st);
    end
  end

  initial begin
    int n = 0;
    while (!done && n < 2000) begin @(posedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 and R11: first cycle after reset, nothing matches
    defaults(); push(0, 0, 0, "R1_R11_reset");
    next(); mem_wr = 1; mem_dest = 1; push(1, 0, 0, "R2_mem_fwd");
    next(); wb_wr = 1; wb_dest = 2; wb_data = 16'h3C3C; push(0, 2, 0, "R3_wb_fwd");
    next(); push(0, 3, 0, "R4_post_wb");
    next(); ex_src_b = 1; mem_wr = 1; mem_dest = 1; wb_wr = 1; wb_dest = 1;
    push(1, 1, 0, "R5_mem_over_wb");
    next(); wb_wr = 1; wb_dest = 1; wb_data = 16'h5A5A; push(2, 0, 0, "R5_wb_over_pw");
    next(); mem_dest = 3; mem_wr = 1; push(3, 0, 0, "R5_R4_pw_only");
    next(); mem_wr = 1; mem_is_load = 1; mem_dest = 1; wb_wr = 1; wb_dest = 1; wb_data = 16'h7777;
    push(2, 0, 0, "R6_load_skipped");
    next(); mem_wr = 1; mem_is_load = 1; mem_dest = 2; push(3, 0, 0, "R6_load_no_src");
    next(); mem_dest = 1; wb_dest = 1; push(0, 0, 0, "R9_invalid_stages");
    next(); ex_is_load = 1; ex_wr = 1; ex_dest = 4; dec_src_a = 4; dec_use_a = 1;
    push(0, 0, 1, "R7_stall_a");
    next(); ex_is_load = 1; ex_wr = 1; ex_dest = 4; dec_src_b = 4; dec_use_b = 1;
    push(0, 0, 1, "R7_stall_b");
    next(); ex_is_load = 1; ex_wr = 1; ex_dest = 4; dec_src_a = 4; dec_src_b = 4;
    push(0, 0, 0, "R8_unused_src");
    next(); ex_wr = 1; ex_dest = 4; dec_src_a = 4; dec_use_a = 1; push(0, 0, 0, "R8_not_load");
    next(); ex_is_load = 1; ex_dest = 4; dec_src_a = 4; dec_use_a = 1; push(0, 0, 0, "R8_no_write");
    next(); ex_src_a = 3; ex_src_b = 5; mem_wr = 1; mem_dest = 5; wb_wr = 1; wb_dest = 3;
    push(2, 1, 0, "R10_independent");
    next(); wb_wr = 1; wb_dest = 1; wb_data = 16'h9999; push(2, 0, 0, "R11_pre");
    @(posedge clk); #1 rst_n = 0;
    defaults(); wb_wr = 1; wb_dest = 1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1; defaults(); prev_wr = 0;
    push(0, 0, 0, "R11_reset_clears");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule